// File: doc/BRIEF.md
# Soft-Decision Add-Compare-Select Core

This block is the metric engine of a soft-input decoder for the rate-1/2, constraint-length-7 convolutional code built from generator taps 171 and 133 (octal). Each clock it may accept one pair of 4-bit soft symbols. It scores the four possible coded pairs against that input and advances all 64 path metrics by one trellis step. The result is one 64-bit word of survivor decisions and the index of the currently cheapest state. A traceback unit downstream reads the decision words and can start from the reported best state.

The 64 metric updates are arranged as 32 radix-2 butterflies, and there is no stall: a new symbol pair can arrive on every clock. Metrics are held in 9 bits. Before each update, the smallest stored metric is subtracted from every predecessor, so the stored values stay near zero however long the stream runs. Each survivor choice is taken from the sign bit of the wrapped difference between the two candidates. A parameter can place a register on the branch metrics. That register sits ahead of the metric feedback loop, so it adds one cycle of latency and leaves the loop itself unchanged.

Top module: `acs_core`

## Requirements
- R1: While reset is asserted, and after it is released, `valid_o` and `dec_o` are 0 and `best_o` is 0. The start metrics are 0 for state 0 and `INIT_BIAS` (default 32) for every other state.
- R2: Soft code 0 is a sure 0 and code 15 is a sure 1. The metric of a branch whose expected pair is (x, y) is |soft_a − 15·x| + |soft_b − 15·y|, where x is compared against `soft_a` and y against `soft_b`.
- R3: A step with input bit u takes state p to state {u, p[5:1]}, so the predecessors of state s are (2s mod 64) and (2s mod 64)+1. Call the lower-order bit of the predecessor b. The expected pair for that transition is the parities of the 7-bit word {s, b} masked with 133 (giving x) and with 171 (giving y).
- R4: The new metric of state s is the smaller of the two candidates (predecessor metric + branch metric). Bit s of `dec_o` is 1 exactly when the candidate from the odd predecessor is strictly smaller. Equal candidates give 0.
- R5: `best_o` is the index of the smallest metric after the most recent step. When several states tie, the lowest index wins.
- R6: The stored metrics never set their most significant bit on any input stream of any length. Decisions and best state match those of unbounded integer arithmetic.
- R7: A symbol pair presented with `sym_valid` high produces its outputs, with `valid_o` high, one clock later when `BM_REG` is 0 and two clocks later when `BM_REG` is 1. A new pair is accepted on every clock.
- R8: While `sym_valid` is low, the soft inputs are ignored. No metric changes, and `dec_o` and `best_o` hold their values.
- R9: Consider noiseless symbols (0/15) produced by an encoder that starts in state 0, holds its last six input bits as the state, and puts the newest bit in state bit 5. For such a stream, `best_o` equals the encoder state after each step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid | input | 1 | A symbol pair is present this clock |
| soft_a | input | 4 | Soft value of the first coded bit (taps 133) |
| soft_b | input | 4 | Soft value of the second coded bit (taps 171) |
| valid_o | output | 1 | `dec_o` and `best_o` reflect a new step |
| dec_o | output | 64 | Survivor choice per state, 1 = odd predecessor |
| best_o | output | 6 | Index of the smallest path metric |

## Verification
The metrics are internal, so a wrong value can reach the ports in two ways. A wrong branch metric or connection flips a bit of `dec_o` on the same step in which it occurs. A wrong metric that does not yet change a choice appears later as a different `best_o` or as a flipped decision a few steps on. The bench therefore compares every decision bit and the best index against an unbounded-integer model on every clock. Noiseless encoded runs tie `best_o` to a known encoder state. Symbol values near mid-scale force equal candidates and tied minima. A long run of extreme symbols exercises the headroom that renormalization must keep.

// File: rtl/acs_core.sv
module acs_core #(
  parameter int K         = 7,
  parameter int SOFT_W    = 4,
  parameter int METRIC_W  = 9,
  parameter int TAPS_A    = 'o133,
  parameter int TAPS_B    = 'o171,
  parameter int INIT_BIAS = 32,
  parameter bit BM_REG    = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sym_valid,
  input  logic [SOFT_W-1:0]     soft_a,
  input  logic [SOFT_W-1:0]     soft_b,
  output logic                  valid_o,
  output logic [(1<<(K-1))-1:0] dec_o,
  output logic [K-2:0]          best_o
);
  localparam int SB   = K - 1;
  localparam int NS   = 1 << SB;
  localparam int HALF = NS / 2;
  localparam int MW   = METRIC_W;
  localparam int BMW  = SOFT_W + 1;
  localparam int SMAX = (1 << SOFT_W) - 1;

  function automatic int parity_of(int v);
    int p = 0;
    for (int i = 0; i < 32; i++) p = p ^ ((v >> i) & 1);
    return p;
  endfunction

  function automatic logic sign_of_diff(logic [MW-1:0] a, logic [MW-1:0] b);
    logic [MW-1:0] t;
    t = a - b;
    return t[MW-1];
  endfunction

  // branch metrics for the four expected pairs, index = {x, y}
  logic [BMW-1:0] bm_now [4];
  for (genvar c = 0; c < 4; c++) begin : g_bm
    localparam int EX = (c >> 1) & 1;
    localparam int EY = c & 1;
    logic [BMW-1:0] da, db;
    assign da = (EX != 0) ? BMW'(SMAX) - BMW'(soft_a) : BMW'(soft_a);
    assign db = (EY != 0) ? BMW'(SMAX) - BMW'(soft_b) : BMW'(soft_b);
    assign bm_now[c] = da + db;
  end

  logic [BMW-1:0] bm [4];
  logic           step;

  if (BM_REG) begin : g_bm_reg
    logic [BMW-1:0] bm_q [4];
    logic           v_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        for (int c = 0; c < 4; c++) bm_q[c] <= '0;
      end else begin
        v_q <= sym_valid;
        if (sym_valid) bm_q <= bm_now;
      end
    end
    assign bm   = bm_q;
    assign step = v_q;
  end else begin : g_bm_comb
    assign bm   = bm_now;
    assign step = sym_valid;
  end

  logic [MW-1:0] pm [NS];
  logic [MW-1:0] pm_nx [NS];
  logic [NS-1:0] dec_nx;
  logic [NS-1:0] pm_hi;

  // argmin tree, leaves in state order, right side wins only when strictly smaller
  logic [MW-1:0] tv [2*NS-1];
  logic [SB-1:0] ti [2*NS-1];
  for (genvar i = 0; i < NS; i++) begin : g_leaf
    assign tv[NS-1+i] = pm[i];
    assign ti[NS-1+i] = SB'(i);
    assign pm_hi[i]   = pm[i][MW-1];
  end
  for (genvar n = 0; n < NS-1; n++) begin : g_node
    logic right;
    assign right = tv[2*n+2] < tv[2*n+1];
    assign tv[n] = right ? tv[2*n+2] : tv[2*n+1];
    assign ti[n] = right ? ti[2*n+2] : ti[2*n+1];
  end

  logic [MW-1:0] floor_m;
  assign floor_m = tv[0];
  assign best_o  = ti[0];

  for (genvar j = 0; j < HALF; j++) begin : g_bfly
    logic [MW-1:0] base0, base1;
    assign base0 = pm[2*j]   - floor_m;
    assign base1 = pm[2*j+1] - floor_m;
    for (genvar u = 0; u < 2; u++) begin : g_acs
      localparam int S  = j + u * HALF;
      localparam int C0 = 2 * parity_of((S << 1) & TAPS_A) + parity_of((S << 1) & TAPS_B);
      localparam int C1 = 2 * parity_of(((S << 1) | 1) & TAPS_A) + parity_of(((S << 1) | 1) & TAPS_B);
      logic [MW-1:0] cand0, cand1;
      assign cand0     = base0 + MW'(bm[C0]);
      assign cand1     = base1 + MW'(bm[C1]);
      assign dec_nx[S] = sign_of_diff(cand1, cand0);
      assign pm_nx[S]  = dec_nx[S] ? cand1 : cand0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) pm[s] <= (s == 0) ? MW'(0) : MW'(INIT_BIAS);
      dec_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= step;
      if (step) begin
        pm    <= pm_nx;
        dec_o <= dec_nx;
      end
    end
  end
endmodule

// File: rtl/acs_core_chk.sv
module acs_core_chk #(
  parameter int NS     = 64,
  parameter int SB     = 6,
  parameter bit BM_REG = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sym_valid,
  input logic          valid_o,
  input logic [NS-1:0] dec_o,
  input logic [NS-1:0] pm_hi,
  input logic [SB-1:0] best_o
);
  assert_metric_headroom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pm_hi == '0);

  assert_dec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !valid_o) |-> $stable(dec_o));

  assert_best_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !valid_o) |-> $stable(best_o));

  if (BM_REG) begin : g_lat2
    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2)) |-> (valid_o == $past(sym_valid, 2)));
  end else begin : g_lat1
    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (valid_o == $past(sym_valid)));
  end
endmodule

bind acs_core acs_core_chk #(.NS(NS), .SB(SB), .BM_REG(BM_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .valid_o(valid_o),
  .dec_o(dec_o), .pm_hi(pm_hi), .best_o(best_o)
);

// File: tb/tb_acs_core.sv
module tb_acs_core;
  localparam int NS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sv = 1'b0;
  logic [3:0] sa = '0, sb = '0;
  logic v1, v2;
  logic [63:0] d1, d2;
  logic [5:0] b1, b2;

  always #2 clk = ~clk;

  acs_core #(.BM_REG(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sv), .soft_a(sa), .soft_b(sb),
    .valid_o(v1), .dec_o(d1), .best_o(b1));

  acs_core #(.BM_REG(1'b1)) dut_piped (
    .clk(clk), .rst_n(rst_n), .sym_valid(sv), .soft_a(sa), .soft_b(sb),
    .valid_o(v2), .dec_o(d2), .best_o(b2));

  int m [NS];
  int nvec = 0, nbad = 0;
  logic e1v, e2v;
  logic [63:0] e1d, e2d;
  int e1b, e2b;

  function automatic int par(int x);
    int p = 0;
    for (int i = 0; i < 32; i++) p = p ^ ((x >> i) & 1);
    return p;
  endfunction

  function automatic int best_of();
    int bi = 0;
    for (int s = 1; s < NS; s++) if (m[s] < m[bi]) bi = s;
    return bi;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NS; s++) m[s] = (s == 0) ? 0 : 32;
    e1v = 0; e2v = 0; e1d = '0; e2d = '0; e1b = 0; e2b = 0;
  endtask

  task automatic model_step(int a, int b, output logic [63:0] dec);
    int nm [NS];
    for (int s = 0; s < NS; s++) begin
      int cost [2];
      for (int k = 0; k < 2; k++) begin
        int pred = ((s << 1) & (NS - 1)) | k;
        int w = (s << 1) | k;
        cost[k] = m[pred] + (par(w & 'o133) != 0 ? 15 - a : a)
                          + (par(w & 'o171) != 0 ? 15 - b : b);
      end
      dec[s] = cost[1] < cost[0];
      nm[s] = dec[s] ? cost[1] : cost[0];
    end
    for (int s = 0; s < NS; s++) m[s] = nm[s];
  endtask

  task automatic check(string tag, string what, logic [63:0] got, logic [63:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic cycle(string tag, bit v, int a, int b);
    logic [63:0] dn;
    @(negedge clk);
    check(tag, "valid", 64'(v1), 64'(e1v));
    check(tag, "decisions", d1, e1d);
    check(tag, "best", 64'(b1), 64'(e1b));
    check("R7", "piped valid", 64'(v2), 64'(e2v));
    check("R7", "piped decisions", d2, e2d);
    check("R7", "piped best", 64'(b2), 64'(e2b));
    e2v = e1v; e2d = e1d; e2b = e1b;
    if (v) begin
      model_step(a, b, dn);
      e1d = dn;
    end
    e1v = v;
    e1b = best_of();
    sv = v; sa = 4'(a); sb = 4'(b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sv = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1", "valid in reset", 64'(v1), 64'd0);
    check("R1", "best in reset", 64'(b1), 64'd0);
    check("R1", "decisions in reset", d1, 64'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL R7 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int st, pend;
    bit have;
    model_reset();
    do_reset();
    cycle("R1", 0, 5, 9);
    cycle("R1", 0, 0, 0);

    // R9: noiseless encoded stream from state 0
    st = 0; have = 0; pend = 0;
    for (int n = 0; n < 300; n++) begin
      int u = int'($urandom_range(0, 1));
      int w = (u << 6) | st;
      int xa = par(w & 'o133) * 15;
      int xb = par(w & 'o171) * 15;
      cycle("R9", 1, xa, xb);
      if (have) check("R9", "best vs encoder state", 64'(b1), 64'(pend));
      st = w >> 1;
      pend = st;
      have = 1;
    end
    cycle("R9", 0, 0, 0);
    check("R9", "best vs encoder state", 64'(b1), 64'(pend));

    // R2/R3: arbitrary soft values
    for (int n = 0; n < 2000; n++)
      cycle("R2", 1, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));

    // R4: mid-scale values force equal candidates
    for (int n = 0; n < 500; n++)
      cycle("R4", 1, int'($urandom_range(7, 8)), int'($urandom_range(7, 8)));

    // R1: reset again mid-stream, then R5 tied minima from the start state
    do_reset();
    cycle("R1", 0, 15, 15);
    for (int n = 0; n < 500; n++) begin
      int a = ($urandom_range(0, 3) == 0) ? 7 : 8;
      cycle("R5", 1, a, 15 - a);
    end

    // R8: gaps with active inputs that must be ignored
    for (int n = 0; n < 800; n++) begin
      bit v = $urandom_range(0, 2) == 0;
      cycle("R8", v, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
    end

    // R6: long run of extreme symbols
    for (int n = 0; n < 20000; n++)
      cycle("R6", 1, 15 * int'($urandom_range(0, 1)), 15 * int'($urandom_range(0, 1)));

    cycle("R7", 0, 0, 0);
    cycle("R7", 0, 0, 0);
    cycle("R7", 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule